// File: doc/BRIEF.md
# Clock Generator Power Sequencer

This controller brings a multi-output clock generator up from cold and takes it down on request. It runs on a free-running reference clock. When the supply detector reports good power, the sequencer starts the PLL. It then waits for the active-low power-good input and captures the frequency-select and multiplier straps at that moment. After a programmable settle delay it releases every clock family. The straps are captured only once per power cycle. Later activity on the power-good or strap pins has no effect until the supply drops.

An asynchronous active-low power-down request is first synchronised. It is then qualified by two consecutive rising edges of the CPU complement clock. After that, the output families are stopped LOW one at a time, each on its own falling edge, in a fixed order: family 0 first, family 1 next, then all remaining families. Once every family is parked, the PLL is switched off. Releasing the request restarts the PLL and, after a wake delay, resumes all families. The CPU differential pair is driven running, parked or high-impedance through a two-bit drive code.

States: OFF (no supply), WAIT_PG (PLL on, waiting for power-good), SETTLE (straps held, delay running), RUN (all families live), STOPPING (families parking in order), DOWN (PLL off) and WAKE (PLL on, restart delay). Transitions:
- power_on: OFF→WAIT_PG.
- pg_seen: WAIT_PG→SETTLE.
- settled: SETTLE→RUN.
- settle_abort: SETTLE→DOWN.
- pd_qualified: RUN→STOPPING.
- all_parked: STOPPING→DOWN.
- pd_released: DOWN→WAKE.
- woken: WAKE→RUN.
- wake_abort: WAKE→DOWN.
- supply_lost: any state→OFF.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: During and right after reset, the outputs are fam_stop all ones, pll_en 0, sel_lat 0 and mult_lat 0. cpu_drive shows the parked code.
- R2: Raising supply_ok moves OFF→WAIT_PG, and pll_en goes 1. pg_n passes through a two-stage synchroniser. The straps are copied to sel_lat/mult_lat on the cycle the synchronised pg_n is seen low. After that, pg_n toggles and strap changes leave sel_lat, mult_lat and fam_stop unchanged until OFF is re-entered.
- R3: fam_stop becomes all zeros exactly SETTLE_CYC+3 reference rising edges after pg_n is driven low in WAIT_PG.
- R4: pd_n passes through a two-stage synchroniser. Stopping begins only after the synchronised pd_n has been low on two consecutive rising edges of cpuc_lvl, as sampled by clk_ref. A high pd_n clears the count. Before qualification, a family falling edge stops nothing.
- R5: In STOPPING, the fam_stop bit of a family rises one clk_ref edge after a sampled falling edge of its fam_lvl, and only in turn. Family 0 may stop at once. Family 1 stops only after family 0. Families 2 and up stop only after family 1. A falling edge out of turn has no effect.
- R6: One edge after the last family stops, the state becomes DOWN. pll_en drops to 0 while fam_stop stays all ones.
- R7: cpu_drive is 2'b00 (running) in RUN and STOPPING. In every other state it is 2'b01 (true held HIGH at reduced drive, complement undriven) when both cpu_hiz_cfg bits are 0. It is 2'b10 (all CPU outputs high-impedance) when either bit is 1.
- R8: In DOWN, a synchronised high pd_n moves to WAKE with pll_en 1. fam_stop clears WAKE_CYC+3 edges after pd_n rises, and this must be below RESTART_MAX.
- R9: A synchronised low pd_n during SETTLE or WAKE goes straight to DOWN (pll_en 0), so outputs are never enabled.
- R10: supply_ok low sends any state to OFF on the next edge. pll_en goes 0, fam_stop goes all ones, and the latched straps clear one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for all logic and timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Analog supply detector result, synchronous to clk_ref |
| pg_n | input | 1 | Active-low power-good, asynchronous |
| sel_strap | input | STRAP_W | Frequency-select strap pins |
| mult_strap | input | 1 | CPU current multiplier strap |
| pd_n | input | 1 | Active-low power-down request, asynchronous |
| cpuc_lvl | input | 1 | CPU complement clock level, sampled by clk_ref |
| fam_lvl | input | NFAM | Level of each clock family, sampled by clk_ref |
| cpu_hiz_cfg | input | 2 | CPU tri-state configuration bits |
| fam_stop | output | NFAM | Per-family stop strobe, 1 = held LOW |
| pll_en | output | 1 | PLL/VCO enable |
| cpu_drive | output | 2 | CPU pair drive code (see R7) |
| sel_lat | output | STRAP_W | Latched frequency-select value |
| mult_lat | output | 1 | Latched multiplier value |

## Verification
The bench feeds family falling edges out of turn: family 1 and family 2 before family 0, and family 2 again before family 1. A sequencer that stopped on any edge, or that only checked its immediate predecessor, would park a family early, and the event scoreboard would flag it. A fall is also driven after only one qualifying CPU edge, which catches a qualifier that counts one edge short. The settle and wake latencies are counted edge by edge, so an off-by-one counter or a missing synchroniser stage shows up as a count mismatch. A power-down dropped into the settle window checks that a design does not run out the delay and briefly enable outputs. Strap and power-good changes after capture check for a design that re-latches.

// File: rtl/cgps_pkg.sv
package cgps_pkg;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_WAIT_PG  = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_RUN      = 3'd3,
        ST_STOPPING = 3'd4,
        ST_DOWN     = 3'd5,
        ST_WAKE     = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        DRV_RUN  = 2'b00,
        DRV_PARK = 2'b01,
        DRV_HIZ  = 2'b10
    } cpu_drive_e;

endpackage

// File: rtl/cgps_sync.sv
module cgps_sync #(
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= {WIDTH{RST_VAL}};
            q    <= {WIDTH{RST_VAL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/cgps_pd_qual.sv
module cgps_pd_qual #(
    parameter int QUAL_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n_s,
    input  logic cpuc_lvl,
    output logic pd_req
);

    localparam int HW = $clog2(QUAL_EDGES + 1);
    localparam logic [HW-1:0] QMAX = HW'(QUAL_EDGES);

    logic          cpuc_q;
    logic          cpuc_rise;
    logic [HW-1:0] hits;

    assign cpuc_rise = cpuc_lvl & ~cpuc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpuc_q <= 1'b0;
            hits   <= '0;
        end else begin
            cpuc_q <= cpuc_lvl;
            if (pd_n_s)
                hits <= '0;
            else if (cpuc_rise && hits != QMAX)
                hits <= hits + 1'b1;
        end
    end

    assign pd_req = (hits == QMAX);

    // R4: qualification completes only on a complement rising edge with request low
    p_qual_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_req) |-> ($past(cpuc_rise) && !$past(pd_n_s)));

    // R4: a released request drops the qualification
    p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n_s |=> !pd_req);

endmodule

// File: rtl/cgps_stop_chain.sv
module cgps_stop_chain #(
    parameter int NFAM = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [NFAM-1:0] fam_lvl,
    output logic [NFAM-1:0] stopped,
    output logic            all_stopped
);

    logic [NFAM-1:0] lvl_q;
    logic [NFAM-1:0] fall;
    logic [NFAM-1:0] turn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= fam_lvl;
    end

    assign fall = lvl_q & ~fam_lvl;

    for (genvar i = 0; i < NFAM; i++) begin : g_fam
        if (i == 0) begin : g_first
            assign turn[i] = 1'b1;
        end else if (i == 1) begin : g_second
            assign turn[i] = stopped[0];
        end else begin : g_rest
            assign turn[i] = stopped[1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stopped[i] <= 1'b0;
            else if (!arm)
                stopped[i] <= 1'b0;
            else if (turn[i] && fall[i])
                stopped[i] <= 1'b1;
        end

        // R5: a family parks only right after its own falling edge while armed
        p_stop_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stopped[i]) |-> $past(fall[i] && arm));
    end

    // R5: family 1 never parks ahead of family 0
    p_second_after_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped[1]) |-> $past(stopped[0]));

    assign all_stopped = &stopped;

endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq
    import cgps_pkg::*;
#(
    parameter int NFAM        = 4,
    parameter int STRAP_W     = 3,
    parameter int SETTLE_CYC  = 3600,
    parameter int WAKE_CYC    = 21000,
    parameter int RESTART_MAX = 25000
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               supply_ok,
    input  logic               pg_n,
    input  logic [STRAP_W-1:0] sel_strap,
    input  logic               mult_strap,
    input  logic               pd_n,
    input  logic               cpuc_lvl,
    input  logic [NFAM-1:0]    fam_lvl,
    input  logic [1:0]         cpu_hiz_cfg,
    output logic [NFAM-1:0]    fam_stop,
    output logic               pll_en,
    output logic [1:0]         cpu_drive,
    output logic [STRAP_W-1:0] sel_lat,
    output logic               mult_lat
);

    localparam int MAXC  = (SETTLE_CYC > WAKE_CYC) ? SETTLE_CYC : WAKE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int LAT_W = $clog2(RESTART_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST   = CNT_W'(WAKE_CYC - 1);
    localparam logic [LAT_W-1:0] LAT_SAT     = LAT_W'(RESTART_MAX);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             latch_straps;
    logic             pg_s, pd_s;
    logic             pd_req;
    logic [NFAM-1:0]  stopped;
    logic             all_stopped;
    cpu_drive_e       drv;

    cgps_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     ({pg_n, pd_n}),
        .q     ({pg_s, pd_s})
    );

    cgps_pd_qual #(.QUAL_EDGES(2)) u_pd_qual (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .pd_n_s   (pd_s),
        .cpuc_lvl (cpuc_lvl),
        .pd_req   (pd_req)
    );

    cgps_stop_chain #(.NFAM(NFAM)) u_stop_chain (
        .clk         (clk_ref),
        .rst_n       (rst_n),
        .arm         (state_q == ST_STOPPING),
        .fam_lvl     (fam_lvl),
        .stopped     (stopped),
        .all_stopped (all_stopped)
    );

    // next state and timer
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        latch_straps = 1'b0;
        if (!supply_ok) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_WAIT_PG;
                ST_WAIT_PG: if (!pg_s) begin
                    state_d      = ST_SETTLE;
                    cnt_d        = '0;
                    latch_straps = 1'b1;
                end
                ST_SETTLE: begin
                    if (!pd_s)                    state_d = ST_DOWN;
                    else if (cnt_q == SETTLE_LAST) state_d = ST_RUN;
                    else                          cnt_d   = cnt_q + 1'b1;
                end
                ST_RUN:      if (pd_req)      state_d = ST_STOPPING;
                ST_STOPPING: if (all_stopped) state_d = ST_DOWN;
                ST_DOWN: if (pd_s) begin
                    state_d = ST_WAKE;
                    cnt_d   = '0;
                end
                ST_WAKE: begin
                    if (!pd_s)                  state_d = ST_DOWN;
                    else if (cnt_q == WAKE_LAST) state_d = ST_RUN;
                    else                        cnt_d   = cnt_q + 1'b1;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register, timer and strap capture
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_OFF;
            cnt_q    <= '0;
            sel_lat  <= '0;
            mult_lat <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (latch_straps) begin
                sel_lat  <= sel_strap;
                mult_lat <= mult_strap;
            end else if (state_q == ST_OFF) begin
                sel_lat  <= '0;
                mult_lat <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        fam_stop = '1;
        pll_en   = 1'b0;
        drv      = (|cpu_hiz_cfg) ? DRV_HIZ : DRV_PARK;
        unique case (state_q)
            ST_WAIT_PG, ST_SETTLE, ST_WAKE: pll_en = 1'b1;
            ST_RUN: begin
                fam_stop = '0;
                pll_en   = 1'b1;
                drv      = DRV_RUN;
            end
            ST_STOPPING: begin
                fam_stop = stopped;
                pll_en   = 1'b1;
                drv      = DRV_RUN;
            end
            default: ;
        endcase
    end

    assign cpu_drive = drv;

    // restart latency watch
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)
            lat_cnt <= '0;
        else if ((state_q == ST_DOWN || state_q == ST_WAKE) && pd_s) begin
            if (lat_cnt != LAT_SAT) lat_cnt <= lat_cnt + 1'b1;
        end else
            lat_cnt <= '0;
    end

    p_restart_bound_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        lat_cnt < LAT_SAT);

    p_strap_hold_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q != ST_OFF && state_q != ST_WAIT_PG &&
         $past(state_q != ST_OFF && state_q != ST_WAIT_PG))
        |-> ($stable(sel_lat) && $stable(mult_lat)));

    p_settle_len_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_SETTLE) |-> $past(cnt_q) == SETTLE_LAST);

    p_pll_after_park_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(pll_en) |-> (&fam_stop));

    p_settle_abort_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (state_q == ST_SETTLE && !pd_s && supply_ok) |=> (state_q == ST_DOWN && !pll_en));

    p_supply_loss_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !supply_ok |=> (state_q == ST_OFF && !pll_en && (&fam_stop)));

    p_drive_idle_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (&fam_stop && !(state_q == ST_STOPPING)) |-> cpu_drive != DRV_RUN);

endmodule

// File: tb/test_clkgen_pwr_seq.sv
module test_clkgen_pwr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NFAM   = 4;
    localparam int SW     = 3;
    localparam int SETTLE = 20;
    localparam int WAKE   = 30;
    localparam int RMAX   = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            supply_ok = 1'b0;
    logic            pg_n = 1'b1;
    logic [SW-1:0]   sel_strap = 3'b101;
    logic            mult_strap = 1'b1;
    logic            pd_n = 1'b1;
    logic            cpuc_lvl = 1'b0;
    logic [NFAM-1:0] fam_lvl = '0;
    logic [1:0]      cpu_hiz_cfg = 2'b00;
    logic [NFAM-1:0] fam_stop;
    logic            pll_en;
    logic [1:0]      cpu_drive;
    logic [SW-1:0]   sel_lat;
    logic            mult_lat;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkgen_pwr_seq #(
        .NFAM(NFAM), .STRAP_W(SW), .SETTLE_CYC(SETTLE),
        .WAKE_CYC(WAKE), .RESTART_MAX(RMAX)
    ) i_clkgen_pwr_seq (
        .clk_ref(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pg_n(pg_n),
        .sel_strap(sel_strap), .mult_strap(mult_strap), .pd_n(pd_n),
        .cpuc_lvl(cpuc_lvl), .fam_lvl(fam_lvl), .cpu_hiz_cfg(cpu_hiz_cfg),
        .fam_stop(fam_stop), .pll_en(pll_en), .cpu_drive(cpu_drive),
        .sel_lat(sel_lat), .mult_lat(mult_lat)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver side of the scoreboard: codes 0..NFAM-1 = family parked,
    // 100 = PLL off, 101 = PLL on, 200 = all families released
    task automatic expect_ev(input int code, input string req);
        exp_q.push_back(code);
        tag_q.push_back(req);
    endtask

    task automatic got_ev(input int code);
        int    e;
        string t;
        if (exp_q.size() == 0) begin
            check(1'b0, "SB", "unexpected event", code, -1);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(e == code, t, "event", code, e);
        end
    endtask

    // monitor side: observe output changes away from the active edge
    logic [NFAM-1:0] prev_stop = '1;
    logic            prev_pll  = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fam_stop != prev_stop) begin
                if (fam_stop == '0) got_ev(200);
                else begin
                    for (int i = 0; i < NFAM; i++)
                        if (fam_stop[i] && !prev_stop[i]) got_ev(i);
                end
            end
            if (pll_en != prev_pll) got_ev(pll_en ? 101 : 100);
        end
        prev_stop = fam_stop;
        prev_pll  = pll_en;
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_fam(input int idx);
        fam_lvl[idx] = 1'b1;
        @(negedge clk);
        fam_lvl[idx] = 1'b0;
        wait_neg(2);
    endtask

    task automatic pulse_cpuc();
        cpuc_lvl = 1'b1;
        @(negedge clk);
        cpuc_lvl = 1'b0;
        @(negedge clk);
    endtask

    task automatic edges_to_run(output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (fam_stop == '0) break;
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        int n;
        wait_neg(3);
        // R1: reset state
        check(fam_stop == '1, "R1", "fam_stop", fam_stop, 15);
        check(pll_en == 1'b0 && sel_lat == '0 && mult_lat == 1'b0, "R1", "pll/straps",
              {pll_en, sel_lat, mult_lat}, 0);
        check(cpu_drive == 2'b01, "R1", "cpu_drive", cpu_drive, 1);
        rst_n = 1'b1;
        wait_neg(2);

        // R2: power on starts the PLL
        expect_ev(101, "R2");
        supply_ok = 1'b1;
        wait_neg(3);
        check(pll_en == 1'b1, "R2", "pll_en", pll_en, 1);

        // R3: settle delay counted from power-good
        expect_ev(200, "R3");
        pg_n = 1'b0;
        edges_to_run(n);
        check(n == SETTLE + 3, "R3", "edges to run", n, SETTLE + 3);
        check(sel_lat == 3'b101 && mult_lat == 1'b1, "R2", "latched straps",
              {sel_lat, mult_lat}, 11);

        // R2: later strap and power-good activity ignored
        pg_n = 1'b1; wait_neg(5);
        sel_strap = 3'b010; mult_strap = 1'b0;
        pg_n = 1'b0; wait_neg(5);
        pg_n = 1'b1; wait_neg(5);
        pg_n = 1'b0; wait_neg(5);
        check(sel_lat == 3'b101 && mult_lat == 1'b1, "R2", "straps after toggles",
              {sel_lat, mult_lat}, 11);
        check(fam_stop == '0, "R2", "fam_stop after toggles", fam_stop, 0);

        // R4: one qualifying edge is not enough
        pd_n = 1'b0;
        wait_neg(4);
        pulse_cpuc();
        pulse_fam(0);
        check(fam_stop == '0, "R4", "one edge only", fam_stop, 0);
        pulse_cpuc();

        // R5: ordered parking with out-of-turn edges
        pulse_fam(1);
        check(fam_stop == 4'b0000, "R5", "fam1 before fam0", fam_stop, 0);
        pulse_fam(2);
        check(fam_stop == 4'b0000, "R5", "fam2 before fam0", fam_stop, 0);
        expect_ev(0, "R5");
        pulse_fam(0);
        check(fam_stop == 4'b0001, "R5", "fam0 parks", fam_stop, 1);
        pulse_fam(2);
        check(fam_stop == 4'b0001, "R5", "fam2 before fam1", fam_stop, 1);
        expect_ev(1, "R5");
        pulse_fam(1);
        check(fam_stop == 4'b0011, "R5", "fam1 parks", fam_stop, 3);
        expect_ev(3, "R5");
        pulse_fam(3);
        check(fam_stop == 4'b1011, "R5", "fam3 parks", fam_stop, 11);
        expect_ev(2, "R5");
        expect_ev(100, "R6");
        pulse_fam(2);
        check(pll_en == 1'b0 && fam_stop == '1, "R6", "pll off after park",
              {pll_en, fam_stop}, 15);

        // R7: drive codes while down
        check(cpu_drive == 2'b01, "R7", "parked code", cpu_drive, 1);
        cpu_hiz_cfg = 2'b10;
        @(negedge clk);
        check(cpu_drive == 2'b10, "R7", "hi-z code", cpu_drive, 2);
        cpu_hiz_cfg = 2'b00;

        // R8: restart latency
        expect_ev(101, "R8");
        expect_ev(200, "R8");
        pd_n = 1'b1;
        edges_to_run(n);
        check(n == WAKE + 3, "R8", "edges to restart", n, WAKE + 3);
        check(n < RMAX, "R8", "restart bound", n, RMAX);
        check(cpu_drive == 2'b00, "R7", "running code", cpu_drive, 0);

        // R10: supply loss
        for (int i = 0; i < NFAM; i++) expect_ev(i, "R10");
        expect_ev(100, "R10");
        supply_ok = 1'b0;
        wait_neg(3);
        check(sel_lat == '0 && mult_lat == 1'b0, "R10", "straps cleared",
              {sel_lat, mult_lat}, 0);
        check(pll_en == 1'b0 && fam_stop == '1, "R10", "off outputs",
              {pll_en, fam_stop}, 15);

        // R9: power-down inside the settle window
        pg_n = 1'b1;
        sel_strap = 3'b011;
        mult_strap = 1'b0;
        expect_ev(101, "R2");
        supply_ok = 1'b1;
        wait_neg(3);
        pg_n = 1'b0;
        wait_neg(8);
        expect_ev(100, "R9");
        pd_n = 1'b0;
        wait_neg(SETTLE + 10);
        check(fam_stop == '1 && pll_en == 1'b0, "R9", "aborted settle",
              {pll_en, fam_stop}, 15);
        check(sel_lat == 3'b011, "R2", "relatched straps", sel_lat, 3);
        expect_ev(101, "R8");
        expect_ev(200, "R8");
        pd_n = 1'b1;
        wait_neg(WAKE + 10);
        check(fam_stop == '0, "R8", "running after abort", fam_stop, 0);

        check(exp_q.size() == 0, "SB", "pending events", exp_q.size(), 0);
        done = 1'b1;
        report();
        $finish;
    end

endmodule